// File: doc/BRIEF.md
# Two-Channel Phase-Frequency Detector with Lock Flag and Monitor Select

This block holds the digital front end of the loop comparators for two synthesizer channels. Each channel receives a divided reference pulse train and a divided feedback pulse train, both synchronous to the block clock. From these the channel produces pump-up and pump-down commands, a high-impedance enable and a current-range select for an external charge pump.

Each channel has its own configuration lines. One selects the phase sense, one forces the pump output into high impedance, one powers the channel down, and one picks the pump current range. Each channel also drives a lock flag. The flag rises after a run of well-aligned reference edges. It dips low for as long as a phase-error pulse is active, and it falls and stays low when a phase error lasts too long.

A registered monitor output shows one internal signal at a time, chosen by a 2-bit group field and a 2-bit index field. It can show a lock flag, a divider pulse train or a power-down (counter-hold) state. A separate output tells the shared reference divider that it may stop, which is allowed only when both channels are powered down.

Top module: `pfd_lock_monitor`

## Requirements
- R1: With the phase-sense bit high, a rising edge on a channel's reference input raises its pump-up output after one clock edge, and a rising edge on its feedback input raises pump-down. Once both pulses have been seen, both outputs are low after the next edge. Rising edges that arrive in the same cycle produce no pulse.
- R2: With the phase-sense bit low, the pump-up and pump-down outputs swap roles, so a reference edge leading the feedback edge drives pump-down.
- R3: While the tri-state bit is high, the channel's high-impedance output is high and both pump outputs are low.
- R4: While the power-down bit is high, the high-impedance output is high, the pump outputs are low and any pending pulse and lock state are cleared. After release, no pulse that was captured during power-down appears.
- R5: The current-select output of each channel follows its current-select input (1 = high-current range, 0 = low-current range).
- R6: After LOCK_EDGES (default 4) reference edges in which no error pulse lasted more than ERR_TOL (default 4) cycles, the lock flag goes high. While locked, the flag is low in exactly those cycles in which an error pulse is active.
- R7: An error pulse that lasts more than ERR_TOL cycles clears the lock. The flag then stays low until LOCK_EDGES new good reference edges have been seen.
- R8: The monitor output is registered, with one cycle of latency. The group/index codes are as follows. Group 00: index 00 = driven low, 01 = lock flag of channel 0, 10 = lock flag of channel 1, 11 = combined lock. Group 01: index 00 = reference input of channel 0, 01 = reference input of channel 1, 10 = feedback input of channel 0, 11 = feedback input of channel 1. Group 10: index 00 = low, 01 = power-down of channel 0, 10 = power-down of channel 1, 11 = both powered down. Group 11: always low.
- R9: The combined lock shown on the monitor is the AND of the two channel lock flags.
- R10: The reference-hold output is high exactly when both channels' power-down bits are high.
- R11: After reset, all pump outputs, lock flags and the monitor output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_pulse_i | input | 2 | Divided reference pulse train, per channel |
| fb_pulse_i | input | 2 | Divided feedback pulse train, per channel |
| sense_pos_i | input | 2 | Phase sense: 1 = positive VCO slope |
| force_hiz_i | input | 2 | Force the pump output into high impedance |
| pwr_down_i | input | 2 | Channel power-down |
| cur_hi_i | input | 2 | Pump current range request |
| mon_grp_i | input | 2 | Monitor group select |
| mon_idx_i | input | 2 | Monitor index select |
| pump_up_o | output | 2 | Pump-up command |
| pump_dn_o | output | 2 | Pump-down command |
| pump_hiz_o | output | 2 | Pump high-impedance enable |
| cur_hi_o | output | 2 | Pump current range select |
| lock_o | output | 2 | Lock flag per channel |
| ref_hold_o | output | 1 | Shared reference divider may stop |
| mon_o | output | 1 | Monitor output |

## Verification
A stuck or stale pulse register shows at the pump outputs one edge after the reference or feedback edge that should have set or cleared it. It also shows as a lock flag that fails to dip or to rise. A wrong error-width or edge count moves the cycle in which the lock flag rises or falls. The bench counts edges and cycles from the requirements to catch a shift of a single period. A wrong monitor code appears on the monitor pin one cycle after the select changes, and the bench covers every group and index through that pin.

// File: rtl/pfd_pkg.sv
// Package: shared codes for the monitor selector and the channel count.
// Assumes: two channels are always present; monitor codes are fixed by R8.
package pfd_pkg;
    localparam int NUM_CH = 2;

    typedef enum logic [1:0] {
        GRP_LOCK  = 2'b00,
        GRP_DIV   = 2'b01,
        GRP_HOLD  = 2'b10,
        GRP_OFF   = 2'b11
    } mon_grp_e;

    // Per-channel status delivered to the monitor selector.
    typedef struct packed {
        logic lock;
        logic ref_p;
        logic fb_p;
        logic down;
    } ch_stat_t;
endpackage

// File: rtl/pfd_core.sv
// Module: pfd_core - edge-triggered phase-frequency detector for one channel.
// Captures rising edges of the reference and feedback pulses, clears both
// pulses together, and applies phase sense, tri-state and power-down gating.
// Assumes: inputs are synchronous to clk; a pulse lasts at least one cycle.
module pfd_core (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    input  logic fb_i,
    input  logic sense_pos_i,
    input  logic force_hiz_i,
    input  logic pwr_down_i,
    output logic pump_up_o,
    output logic pump_dn_o,
    output logic hiz_o,
    output logic ref_rise_o,
    output logic err_o
);
    logic ref_d, fb_d;
    logic up_q, dn_q;
    logic up_n, dn_n;
    logic fb_rise;

    assign ref_rise_o = ref_i & ~ref_d;
    assign fb_rise    = fb_i & ~fb_d;

    // Edge history registers; they keep running during power-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_d <= 1'b0;
            fb_d  <= 1'b0;
        end else begin
            ref_d <= ref_i;
            fb_d  <= fb_i;
        end
    end

    // Next pulse state: set on edges, clear together once both are seen.
    always_comb begin
        up_n = up_q | ref_rise_o;
        dn_n = dn_q | fb_rise;
        if (up_n && dn_n) begin
            up_n = 1'b0;
            dn_n = 1'b0;
        end
    end

    // Pulse registers, held clear in power-down.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down_i) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            up_q <= up_n;
            dn_q <= dn_n;
        end
    end

    assign hiz_o     = force_hiz_i | pwr_down_i;
    assign err_o     = up_q | dn_q;
    assign pump_up_o = ~hiz_o & (sense_pos_i ? up_q : dn_q);
    assign pump_dn_o = ~hiz_o & (sense_pos_i ? dn_q : up_q);

    // R1: the two pulse registers are never set together.
    assert_pulse_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_q && dn_q));
    // R1: an up pulse only starts after a reference rising edge.
    assert_up_from_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_q) |-> $past(ref_i && !ref_d));
    // R4: power-down leaves no pending pulse.
    assert_pdn_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down_i |=> (!up_q && !dn_q));
endmodule

// File: rtl/lock_det.sv
// Module: lock_det - lock flag for one channel.
// Counts reference edges with short error pulses; an over-long error drops
// lock. The flag dips low while an error pulse is active.
// Assumes: err_i is high exactly while a pump pulse is pending.
module lock_det #(
    parameter int ERR_TOL    = 4,
    parameter int LOCK_EDGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down_i,
    input  logic ref_rise_i,
    input  logic err_i,
    output logic lock_o
);
    localparam int WID_W = $clog2(ERR_TOL + 1);
    localparam int CNT_W = (LOCK_EDGES > 1) ? $clog2(LOCK_EDGES) : 1;
    localparam logic [WID_W-1:0] WID_MAX  = WID_W'(ERR_TOL);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_EDGES - 1);

    logic [WID_W-1:0] wid_q;
    logic [CNT_W-1:0] good_q;
    logic             locked_q;
    logic             over;

    assign over = err_i && (wid_q == WID_MAX);

    // Error-width counter, saturating at the tolerance.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down_i)
            wid_q <= '0;
        else if (!err_i)
            wid_q <= '0;
        else if (wid_q != WID_MAX)
            wid_q <= wid_q + 1'b1;
    end

    // Good-edge counter and lock state; an over-long error wins.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down_i) begin
            good_q   <= '0;
            locked_q <= 1'b0;
        end else if (over) begin
            good_q   <= '0;
            locked_q <= 1'b0;
        end else if (ref_rise_i) begin
            if (good_q == CNT_LAST)
                locked_q <= 1'b1;
            else
                good_q <= good_q + 1'b1;
        end
    end

    assign lock_o = locked_q & ~err_i;

    // R7: an error over the tolerance drops lock on the next edge.
    assert_overlong_unlock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        over |=> !locked_q);
    // R6: lock can only be gained on a reference edge.
    assert_lock_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_q) |-> $past(ref_rise_i));
endmodule

// File: rtl/mon_mux.sv
// Module: mon_mux - registered monitor selector over both channels.
// Assumes: the group/index code table of R8.
module mon_mux
    import pfd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         grp_i,
    input  logic [1:0]         idx_i,
    input  ch_stat_t [NUM_CH-1:0] stat_i,
    output logic               mon_o
);
    logic mon_n;

    // Source selection from group and index.
    always_comb begin
        mon_n = 1'b0;
        case (mon_grp_e'(grp_i))
            GRP_LOCK: case (idx_i)
                2'b01:   mon_n = stat_i[0].lock;
                2'b10:   mon_n = stat_i[1].lock;
                2'b11:   mon_n = stat_i[0].lock & stat_i[1].lock;
                default: mon_n = 1'b0;
            endcase
            GRP_DIV: case (idx_i)
                2'b00:   mon_n = stat_i[0].ref_p;
                2'b01:   mon_n = stat_i[1].ref_p;
                2'b10:   mon_n = stat_i[0].fb_p;
                default: mon_n = stat_i[1].fb_p;
            endcase
            GRP_HOLD: case (idx_i)
                2'b01:   mon_n = stat_i[0].down;
                2'b10:   mon_n = stat_i[1].down;
                2'b11:   mon_n = stat_i[0].down & stat_i[1].down;
                default: mon_n = 1'b0;
            endcase
            default: mon_n = 1'b0;
        endcase
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) mon_o <= 1'b0;
        else        mon_o <= mon_n;
    end

    // R8: the off group always yields a low monitor on the next cycle.
    assert_mon_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_i == 2'b11) |=> !mon_o);
endmodule

// File: rtl/pfd_lock_monitor.sv
// Module: pfd_lock_monitor - top: two detector channels, lock flags,
// monitor selector and shared reference-hold output.
// Assumes: all inputs synchronous to clk; synchronous active-low reset.
module pfd_lock_monitor
    import pfd_pkg::*;
#(
    parameter int ERR_TOL    = 4,
    parameter int LOCK_EDGES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ref_pulse_i,
    input  logic [1:0] fb_pulse_i,
    input  logic [1:0] sense_pos_i,
    input  logic [1:0] force_hiz_i,
    input  logic [1:0] pwr_down_i,
    input  logic [1:0] cur_hi_i,
    input  logic [1:0] mon_grp_i,
    input  logic [1:0] mon_idx_i,
    output logic [1:0] pump_up_o,
    output logic [1:0] pump_dn_o,
    output logic [1:0] pump_hiz_o,
    output logic [1:0] cur_hi_o,
    output logic [1:0] lock_o,
    output logic       ref_hold_o,
    output logic       mon_o
);
    ch_stat_t [NUM_CH-1:0] stat;

    // One detector and lock flag per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic rise, err;

        pfd_core u_pfd (
            .clk         (clk),
            .rst_n       (rst_n),
            .ref_i       (ref_pulse_i[c]),
            .fb_i        (fb_pulse_i[c]),
            .sense_pos_i (sense_pos_i[c]),
            .force_hiz_i (force_hiz_i[c]),
            .pwr_down_i  (pwr_down_i[c]),
            .pump_up_o   (pump_up_o[c]),
            .pump_dn_o   (pump_dn_o[c]),
            .hiz_o       (pump_hiz_o[c]),
            .ref_rise_o  (rise),
            .err_o       (err)
        );

        lock_det #(.ERR_TOL(ERR_TOL), .LOCK_EDGES(LOCK_EDGES)) u_lock (
            .clk        (clk),
            .rst_n      (rst_n),
            .pwr_down_i (pwr_down_i[c]),
            .ref_rise_i (rise),
            .err_i      (err),
            .lock_o     (lock_o[c])
        );

        assign stat[c].lock  = lock_o[c];
        assign stat[c].ref_p = ref_pulse_i[c];
        assign stat[c].fb_p  = fb_pulse_i[c];
        assign stat[c].down  = pwr_down_i[c];
    end

    assign cur_hi_o   = cur_hi_i;
    assign ref_hold_o = &pwr_down_i;

    mon_mux u_mon (
        .clk    (clk),
        .rst_n  (rst_n),
        .grp_i  (mon_grp_i),
        .idx_i  (mon_idx_i),
        .stat_i (stat),
        .mon_o  (mon_o)
    );

    // R3: a high-impedance channel never commands the pump.
    assert_hiz_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        force_hiz_i[0] |-> (!pump_up_o[0] && !pump_dn_o[0]));
endmodule

// File: tb/pfd_lock_monitor_tb_top.sv
module pfd_lock_monitor_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ref_p = '0, fb_p = '0, sense = 2'b11, fhiz = '0, pdn = '0, cur = '0;
    logic [1:0] grp = '0, idx = '0;
    logic [1:0] up, dn, hiz, cur_o, lock;
    logic       hold, mon;
    int         n_chk = 0, n_fail = 0, cyc = 0;

    always #4 clk = ~clk;

    pfd_lock_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .ref_pulse_i(ref_p), .fb_pulse_i(fb_p),
        .sense_pos_i(sense), .force_hiz_i(fhiz), .pwr_down_i(pdn),
        .cur_hi_i(cur), .mon_grp_i(grp), .mon_idx_i(idx),
        .pump_up_o(up), .pump_dn_o(dn), .pump_hiz_o(hiz), .cur_hi_o(cur_o),
        .lock_o(lock), .ref_hold_o(hold), .mon_o(mon)
    );

    // Row fields: [10:9] grp, [8:7] idx, [6:5] ref, [4:3] fb, [2:1] pdn, [0] expected monitor
    localparam logic [10:0] VEC [13] = '{
        11'b00_00_11_00_00_0,
        11'b01_00_01_00_00_1,
        11'b01_00_10_00_00_0,
        11'b01_01_10_00_00_1,
        11'b01_10_00_01_00_1,
        11'b01_11_00_01_00_0,
        11'b01_11_00_10_00_1,
        11'b10_01_00_00_01_1,
        11'b10_10_00_00_01_0,
        11'b10_11_00_00_01_0,
        11'b10_11_00_00_11_1,
        11'b11_01_11_00_11_0,
        11'b10_00_00_00_11_0
    };

    task automatic chk(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic lock_ch(int c);
        for (int k = 0; k < 5; k++) begin
            ref_p[c] = 1'b1; fb_p[c] = 1'b1; tick(1);
            ref_p[c] = 1'b0; fb_p[c] = 1'b0; tick(7);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got %0d expected 0", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        // R11: reset state
        chk("R11 up", up, 0); chk("R11 dn", dn, 0);
        chk("R11 lock", lock, 0); chk("R11 mon", mon, 0);

        // R8 table walk
        for (int i = 0; i < 13; i++) begin
            grp = VEC[i][10:9]; idx = VEC[i][8:7]; ref_p = VEC[i][6:5];
            fb_p = VEC[i][4:3]; pdn = VEC[i][2:1];
            tick(1);
            chk($sformatf("R8 row %0d", i), mon, VEC[i][0]);
        end
        chk("R10 hold both", hold, 1);
        pdn = 2'b01; tick(1);
        chk("R10 hold one", hold, 0);
        pdn = 2'b00; ref_p = '0; fb_p = '0; grp = '0; idx = '0; tick(2);

        // R1: reference leads
        ref_p[0] = 1'b1; tick(1);
        chk("R1 up set", up[0], 1); chk("R1 dn idle", dn[0], 0);
        fb_p[0] = 1'b1; tick(1);
        chk("R1 up cleared", up[0], 0); chk("R1 dn cleared", dn[0], 0);
        ref_p[0] = 1'b0; fb_p[0] = 1'b0; tick(2);
        // R1: feedback leads
        fb_p[0] = 1'b1; tick(1);
        chk("R1 dn set", dn[0], 1); chk("R1 up idle", up[0], 0);
        ref_p[0] = 1'b1; tick(1);
        chk("R1 dn cleared2", dn[0], 0);
        ref_p[0] = 1'b0; fb_p[0] = 1'b0; tick(2);
        // R1: simultaneous edges give no pulse
        ref_p[1] = 1'b1; fb_p[1] = 1'b1; tick(1);
        chk("R1 simul up", up[1], 0); chk("R1 simul dn", dn[1], 0);
        ref_p[1] = 1'b0; fb_p[1] = 1'b0; tick(2);

        // R2: reversed sense
        sense[0] = 1'b0; ref_p[0] = 1'b1; tick(1);
        chk("R2 dn from ref", dn[0], 1); chk("R2 up quiet", up[0], 0);
        fb_p[0] = 1'b1; tick(1);
        ref_p[0] = 1'b0; fb_p[0] = 1'b0; sense[0] = 1'b1; tick(2);

        // R3: forced high impedance
        fhiz[0] = 1'b1; ref_p[0] = 1'b1; tick(1);
        chk("R3 hiz", hiz[0], 1); chk("R3 up gated", up[0], 0);
        fb_p[0] = 1'b1; tick(1);
        fhiz[0] = 1'b0; ref_p[0] = 1'b0; fb_p[0] = 1'b0; tick(2);
        chk("R3 hiz released", hiz[0], 0);

        // R4: power-down and no stale pulse
        pdn[0] = 1'b1; ref_p[0] = 1'b1; tick(1);
        chk("R4 hiz", hiz[0], 1); chk("R4 up gated", up[0], 0);
        pdn[0] = 1'b0; tick(1);
        chk("R4 no stale", up[0], 0);
        ref_p[0] = 1'b0; tick(2);

        // R5: current range
        cur = 2'b10; tick(1);
        chk("R5 cur", cur_o, 2);
        cur = 2'b00;

        // R6: lock acquisition and dip on a short error
        grp = 2'b00; idx = 2'b01;
        lock_ch(0);
        chk("R6 locked", lock[0], 1); chk("R6 mon lock0", mon, 1);
        ref_p[0] = 1'b1; tick(1);
        chk("R6 dip", lock[0], 0);
        fb_p[0] = 1'b1; tick(1);
        chk("R6 after dip", lock[0], 1);
        ref_p[0] = 1'b0; fb_p[0] = 1'b0; tick(4);

        // R9: combined lock is an AND
        idx = 2'b11; tick(1);
        chk("R9 one locked", mon, 0);
        lock_ch(1);
        chk("R9 both locked", mon, 1);

        // R7: over-long error drops and holds lock low
        ref_p[0] = 1'b1; tick(8);
        chk("R7 unlocked", lock[0], 0);
        fb_p[0] = 1'b1; tick(1);
        chk("R7 stays low", lock[0], 0);
        ref_p[0] = 1'b0; fb_p[0] = 1'b0; tick(4);
        chk("R7 still low", lock[0], 0);

        // R4: power-down clears lock of channel 1
        pdn[1] = 1'b1; tick(1);
        pdn[1] = 1'b0; tick(2);
        chk("R4 lock cleared", lock[1], 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule